// File: doc/BRIEF.md
# Coprocessor Program Start Gate

This block decides whether a graphics coprocessor may begin fetching instructions from its current program location. The location is an 8-bit program bank and a 16-bit program counter. The gate sorts the bank into one memory region: ROM, work RAM, or one of three unmapped gaps. It then checks that region against the ROM and RAM access grants that the host has placed in the screen-mode register. A program counter that falls inside an enabled instruction-cache window skips all of these tests and is always allowed to start.

The permission result is combinational, so the host can see it at once. The same block also reports the region code and the physical ROM and RAM bank indices that the bank number maps to.

A one-cycle start request latches the verdict into the run flag. A permitted start sets the flag. A refused start clears the flag and raises a one-cycle refusal pulse, so no instruction is fetched.

Top module: `pstart_gate`

## Requirements
- R1: When the cache is enabled and cache_base <= pc < cache_base + WINDOW (WINDOW = 512 by default, computed without 16-bit wrap), start_ok is 1 whatever the bank and grants are.
- R2: Outside a cache hit, a bank below 0x40 with pc below 0x8000 is refused, and region_code is 2.
- R3: Outside a cache hit, banks 0x60 to 0x6F are refused, and region_code is 3.
- R4: Outside a cache hit, banks 0x74 to 0xFF are refused, and region_code is 4.
- R5: Banks 0x70 to 0x73 are RAM (region_code 1). Outside a cache hit they are permitted exactly when ram_grant is 1.
- R6: Every other bank/pc combination is ROM (region_code 0). Outside a cache hit it is permitted exactly when rom_grant is 1.
- R7: ram_index equals bank[1:0] modulo RAM_BANKS (RAM_BANKS = 2 by default).
- R8: rom_index equals bank[6:0] modulo ROM_BANKS (ROM_BANKS = 32 by default).
- R9: A start request sampled with start_ok = 1 gives run_flag = 1 and start_refused = 0 after that clock edge. A start request with start_ok = 0 gives run_flag = 0 and start_refused = 1 for one cycle.
- R10: In a cycle with no start request, run_flag holds its value and start_refused is 0 after the edge.
- R11: During reset, run_flag and start_refused are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_bank | input | 8 | Program bank number |
| prog_pc | input | 16 | Program counter |
| rom_grant | input | 1 | Coprocessor owns ROM bus |
| ram_grant | input | 1 | Coprocessor owns RAM bus |
| cache_on | input | 1 | Instruction cache window enabled |
| cache_base | input | 16 | Start address of cache window |
| start_req | input | 1 | One-cycle request to start execution |
| start_ok | output | 1 | Combinational start permission |
| region_code | output | 3 | Region: 0 ROM, 1 RAM, 2 low gap, 3 mid hole, 4 high |
| ram_index | output | RAM_IW | Physical RAM bank index |
| rom_index | output | ROM_IW | Physical ROM bank index |
| run_flag | output | 1 | Registered go flag |
| start_refused | output | 1 | One-cycle pulse after a refused request |

## Verification
Every one of the 256 bank values is driven with program counters 0x0000, 0x7FFF, 0x8000 and 0xFFFF and with all four grant combinations. This separates the low-gap rule from ROM at the 0x8000 boundary, and it shows that RAM depends only on ram_grant and ROM only on rom_grant. Separate cache patterns put the counter at base - 1, at base, at base + WINDOW - 1 and at base + WINDOW, with the base near the top of the address space. These show that the window is half-open and does not wrap, and that a hit overrides refused regions. Start requests are interleaved with idle cycles against a behavioural model, so a latched verdict is distinguished from the flag simply holding.

// File: rtl/pstart_pkg.sv
package pstart_pkg;

    typedef enum logic [2:0] {
        RGN_ROM  = 3'd0,
        RGN_RAM  = 3'd1,
        RGN_LOW  = 3'd2,
        RGN_HOLE = 3'd3,
        RGN_HIGH = 3'd4
    } region_e;

    typedef struct packed {
        logic run;
        logic refused;
    } gate_state_t;

endpackage

// File: rtl/pstart_cache_window.sv
module pstart_cache_window #(
    parameter int ADDR_W = 16,
    parameter int WINDOW = 512
) (
    input  logic              cache_on,
    input  logic [ADDR_W-1:0] cache_base,
    input  logic [ADDR_W-1:0] pc,
    output logic              hit
);
    localparam int SUM_W = ADDR_W + 1;
    localparam logic [SUM_W-1:0] WIN_EXT = SUM_W'(WINDOW);

    logic [SUM_W-1:0] limit_d;
    logic             above_d;
    logic             below_d;

    always_comb begin
        limit_d = {1'b0, cache_base} + WIN_EXT;
        above_d = (pc >= cache_base);
        below_d = ({1'b0, pc} < limit_d);
        hit     = cache_on & above_d & below_d;
    end
endmodule

// File: rtl/pstart_bank_decode.sv
module pstart_bank_decode
    import pstart_pkg::*;
#(
    parameter int RAM_BANKS = 2,
    parameter int ROM_BANKS = 32,
    parameter int RAM_IW    = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1,
    parameter int ROM_IW    = (ROM_BANKS > 1) ? $clog2(ROM_BANKS) : 1
) (
    input  logic [7:0]        bank,
    input  logic [15:0]       pc,
    output region_e           region,
    output logic [RAM_IW-1:0] ram_idx,
    output logic [ROM_IW-1:0] rom_idx
);
    localparam logic [7:0] LOW_TOP   = 8'h40;
    localparam logic [7:0] HOLE_LO   = 8'h60;
    localparam logic [7:0] HOLE_HI   = 8'h6F;
    localparam logic [7:0] RAM_LO    = 8'h70;
    localparam logic [7:0] RAM_HI    = 8'h73;
    localparam logic [7:0] HIGH_LO   = 8'h74;

    region_e region_d;

    always_comb begin
        if ((bank < LOW_TOP) && !pc[15])
            region_d = RGN_LOW;
        else if ((bank >= HOLE_LO) && (bank <= HOLE_HI))
            region_d = RGN_HOLE;
        else if (bank >= HIGH_LO)
            region_d = RGN_HIGH;
        else if ((bank >= RAM_LO) && (bank <= RAM_HI))
            region_d = RGN_RAM;
        else
            region_d = RGN_ROM;
        region = region_d;
    end

    generate
        if (RAM_BANKS > 1) begin : g_ram_mod
            always_comb ram_idx = RAM_IW'(int'(bank[1:0]) % RAM_BANKS);
        end else begin : g_ram_one
            always_comb ram_idx = '0;
        end
        if (ROM_BANKS > 1) begin : g_rom_mod
            always_comb rom_idx = ROM_IW'(int'(bank[6:0]) % ROM_BANKS);
        end else begin : g_rom_one
            always_comb rom_idx = '0;
        end
    endgenerate
endmodule

// File: rtl/pstart_gate.sv
module pstart_gate
    import pstart_pkg::*;
#(
    parameter int WINDOW    = 512,
    parameter int RAM_BANKS = 2,
    parameter int ROM_BANKS = 32,
    parameter int RAM_IW    = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1,
    parameter int ROM_IW    = (ROM_BANKS > 1) ? $clog2(ROM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        prog_bank,
    input  logic [15:0]       prog_pc,
    input  logic              rom_grant,
    input  logic              ram_grant,
    input  logic              cache_on,
    input  logic [15:0]       cache_base,
    input  logic              start_req,
    output logic              start_ok,
    output logic [2:0]        region_code,
    output logic [RAM_IW-1:0] ram_index,
    output logic [ROM_IW-1:0] rom_index,
    output logic              run_flag,
    output logic              start_refused
);
    logic        hit;
    region_e     region;
    gate_state_t st_d, st_q;
    logic        ok_d;

    pstart_cache_window #(.ADDR_W(16), .WINDOW(WINDOW)) u_win (
        .cache_on  (cache_on),
        .cache_base(cache_base),
        .pc        (prog_pc),
        .hit       (hit)
    );

    pstart_bank_decode #(
        .RAM_BANKS(RAM_BANKS), .ROM_BANKS(ROM_BANKS),
        .RAM_IW(RAM_IW), .ROM_IW(ROM_IW)
    ) u_dec (
        .bank   (prog_bank),
        .pc     (prog_pc),
        .region (region),
        .ram_idx(ram_index),
        .rom_idx(rom_index)
    );

    always_comb begin
        if (hit)
            ok_d = 1'b1;
        else begin
            unique case (region)
                RGN_RAM: ok_d = ram_grant;
                RGN_ROM: ok_d = rom_grant;
                default: ok_d = 1'b0;
            endcase
        end

        st_d = st_q;
        st_d.refused = 1'b0;
        if (start_req) begin
            st_d.run     = ok_d;
            st_d.refused = ~ok_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign start_ok      = ok_d;
    assign region_code   = region;
    assign run_flag      = st_q.run;
    assign start_refused = st_q.refused;

    a_r1_cache_override: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> start_ok);

    a_r3_hole_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && region == RGN_HOLE) |-> !start_ok);

    a_r9_refuse_clears_go: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && !start_ok) |=> (!run_flag && start_refused));

    a_r9_accept_sets_go: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && start_ok) |=> (run_flag && !start_refused));

    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !start_req |=> ($stable(run_flag) && !start_refused));
endmodule

// File: tb/sim_pstart_gate.sv
module sim_pstart_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  prog_bank = '0;
    logic [15:0] prog_pc = '0;
    logic        rom_grant = 1'b0;
    logic        ram_grant = 1'b0;
    logic        cache_on = 1'b0;
    logic [15:0] cache_base = '0;
    logic        start_req = 1'b0;
    logic        start_ok;
    logic [2:0]  region_code;
    logic [0:0]  ram_index;
    logic [4:0]  rom_index;
    logic        run_flag;
    logic        start_refused;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_run = 0;
    int exp_ref = 0;
    int step    = 0;

    always #5 clk = ~clk;

    pstart_gate u0 (
        .clk(clk), .rst_n(rst_n), .prog_bank(prog_bank), .prog_pc(prog_pc),
        .rom_grant(rom_grant), .ram_grant(ram_grant), .cache_on(cache_on),
        .cache_base(cache_base), .start_req(start_req), .start_ok(start_ok),
        .region_code(region_code), .ram_index(ram_index), .rom_index(rom_index),
        .run_flag(run_flag), .start_refused(start_refused)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (bank=%h pc=%h)",
                     tag, act, exp, prog_bank, prog_pc);
        end
    endtask

    function automatic int model_region(input int b, input int p);
        if (b < 64 && p < 32768) return 2;
        if (b >= 96 && b <= 111) return 3;
        if (b >= 116) return 4;
        if (b >= 112 && b <= 115) return 1;
        return 0;
    endfunction

    task automatic apply(input int b, input int p, input int rg, input int mg,
                         input int con, input int cb, input int req);
        int rgn, hit, ok;
        string tag;
        @(negedge clk);
        prog_bank = 8'(b); prog_pc = 16'(p); rom_grant = rg[0]; ram_grant = mg[0];
        cache_on = con[0]; cache_base = 16'(cb); start_req = req[0];
        #2;
        rgn = model_region(b, p);
        hit = (con != 0 && p >= cb && p < cb + 512) ? 1 : 0;
        if (hit != 0) begin ok = 1; tag = "R1"; end
        else case (rgn)
            0: begin ok = rg; tag = "R6"; end
            1: begin ok = mg; tag = "R5"; end
            2: begin ok = 0;  tag = "R2"; end
            3: begin ok = 0;  tag = "R3"; end
            default: begin ok = 0; tag = "R4"; end
        endcase
        check(tag, int'(start_ok), ok);
        check({tag, " region"}, int'(region_code), rgn);
        check("R7 ram_index", int'(ram_index), (b % 4) % 2);
        check("R8 rom_index", int'(rom_index), (b % 128) % 32);
        if (req != 0) begin exp_run = ok; exp_ref = (ok == 0) ? 1 : 0; end
        else exp_ref = 0;
        @(posedge clk); #1;
        check(req != 0 ? "R9 run" : "R10 run", int'(run_flag), exp_run);
        check(req != 0 ? "R9 refused" : "R10 refused", int'(start_refused), exp_ref);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R11 run", int'(run_flag), 0);
        check("R11 refused", int'(start_refused), 0);
        @(negedge clk); rst_n = 1'b1;
        for (int b = 0; b < 256; b++) begin
            for (int pi = 0; pi < 4; pi++) begin
                int p;
                p = (pi == 0) ? 0 : (pi == 1) ? 32767 : (pi == 2) ? 32768 : 65535;
                for (int g = 0; g < 4; g++) begin
                    step++;
                    apply(b, p, g % 2, g / 2, 0, 0, (step % 3 == 0) ? 1 : 0);
                end
            end
        end
        // R1 window boundaries, base near top, no wrap
        apply(8'h65, 16'hFDFF, 0, 0, 1, 16'hFE00, 1);
        apply(8'h65, 16'hFE00, 0, 0, 1, 16'hFE00, 1);
        apply(8'h80, 16'hFFFF, 0, 0, 1, 16'hFE00, 0);
        apply(8'h10, 16'h0000, 0, 0, 1, 16'hFE00, 1);
        apply(8'h10, 16'h1000, 0, 0, 1, 16'h1000, 1);
        apply(8'h10, 16'h11FF, 0, 0, 1, 16'h1000, 0);
        apply(8'h10, 16'h1200, 0, 0, 1, 16'h1000, 1);
        apply(8'h10, 16'h1100, 0, 0, 0, 16'h1000, 1);
        apply(8'h71, 16'h1100, 0, 0, 1, 16'h1000, 1);
        apply(8'h71, 16'h1100, 0, 0, 1, 16'h1000, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule